// File: doc/BRIEF.md
# PCIe Root-Port Interrupt Collector

This block merges the interrupt sources of one PCIe root port into a single level interrupt for the host CPU. The sources are four legacy INTx virtual wires and up to 32 message-signalled interrupt (MSI) vectors. Inbound MSI memory writes reach the block on a plain capture interface (valid, 32-bit address, 32-bit data). A write is taken only when its address equals the programmed capture address and its data names an existing vector. A taken write sets that vector's bit in a per-vector status word. It also sets one MSI summary bit in the main status word, next to the INTx bits.

Software uses a 32-bit register bus to reach the mask, main status, per-vector status and capture address. Both status words are write-one-to-clear. The two MSI levels are cleared independently: software drains the per-vector word, then clears the summary bit with its own write. The summary bit is held by a two-state machine. `SUM_IDLE` goes to `SUM_PEND` when an MSI is accepted. `SUM_PEND` goes back to `SUM_IDLE` only on a software clear of the summary bit in a cycle with no accepted MSI. It stays in `SUM_PEND` otherwise, including when a clear and an accept arrive together. A dropped MSI is recorded in a sticky error bit.

Top module: `pcie_irq_collector`

## Requirements
- R1: After reset, the mask register (offset 0x420) reads 0x008F0000, so bits 19:16 and bit 23 are set and all sources are masked. The main status (0x424), vector status (0x42C) and capture address (0x430) read 0, and `irq_out` is 0.
- R2: A pulse on `intx_assert[i]` sets main-status bit 16+i (INTA..INTD = bits 16..19). Writing 1 to that bit at 0x424 clears it.
- R3: An MSI write with `msi_valid`=1, `msi_addr` equal to the capture address at 0x430 and `msi_data` below 32 sets bit `msi_data` of the vector status at 0x42C. Writing 1 to a vector bit clears it.
- R4: An accepted MSI sets main-status bit 23 (summary). Clearing vector bits leaves the summary set. Only a write of 1 to bit 23 at 0x424 clears it.
- R5: A set and a clear of the same status bit in the same cycle leave the bit set. This holds for the summary, vector and INTx bits.
- R6: An MSI write whose address mismatches, or whose data is 32 or more, changes no vector bit and no summary bit. It sets sticky error bit 24 of 0x424, which is write-one-to-clear.
- R7: `irq_out` is registered. One cycle after the status or mask changes, it equals the OR of main-status bits 19:16 and 23 whose mask bits are 0.
- R8: Status bits record events while their sources are masked. Clearing the mask then raises `irq_out`.
- R9: Only mask bits 19:16 and 23 are writable, and all other mask bits read 0. Error bit 24 never drives `irq_out`.
- R10: Reads of any offset other than the four registers return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| intx_assert | input | 4 | INTA..INTD event pulses |
| msi_valid | input | 1 | Inbound MSI write valid |
| msi_addr | input | 32 | Inbound MSI write address |
| msi_data | input | 32 | Inbound MSI write data (vector number) |
| irq_out | output | 1 | Level interrupt to the host CPU |

## Verification
The bench targets the cases where an event and a clear of the same bit land on the same edge. A design that let the clear win would lose an MSI. It also checks that the summary bit survives a full drain of the vector word. A design that derived the summary from the vector bits would drop it on that drain, and the interrupt would vanish before software cleared it. It sends MSIs with a wrong address and with data 32. A design without range and address checks would set a vector or wrap the index onto vector 0. Finally, it masks sources before events arrive. A design that gated the status with the mask would then lose the events when the mask is lifted.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
    localparam int REG_AW   = 12;
    localparam int REG_DW   = 32;
    localparam int N_INTX   = 4;
    localparam int INTX_LSB = 16;
    localparam int SUM_BIT  = 23;
    localparam int ERR_BIT  = 24;

    localparam logic [REG_AW-1:0] OFS_MASK = 12'h420;
    localparam logic [REG_AW-1:0] OFS_STAT = 12'h424;
    localparam logic [REG_AW-1:0] OFS_VEC  = 12'h42C;
    localparam logic [REG_AW-1:0] OFS_CAP  = 12'h430;

    typedef enum logic [0:0] {
        SUM_IDLE = 1'b0,
        SUM_PEND = 1'b1
    } sum_state_e;
endpackage

// File: rtl/pirq_msi_capture.sv
module pirq_msi_capture #(
    parameter int NVEC = 32,
    parameter int AW   = 32,
    parameter int DW   = 32
) (
    input  logic            msi_valid,
    input  logic [AW-1:0]   msi_addr,
    input  logic [DW-1:0]   msi_data,
    input  logic [AW-1:0]   cap_addr,
    output logic            accept,
    output logic            drop,
    output logic [NVEC-1:0] set_vec
);
    localparam int VIDX = (NVEC > 1) ? $clog2(NVEC) : 1;

    logic addr_hit;
    logic data_ok;

    assign addr_hit = (msi_addr == cap_addr);
    assign data_ok  = (msi_data < DW'(NVEC));
    assign accept   = msi_valid && addr_hit && data_ok;
    assign drop     = msi_valid && !(addr_hit && data_ok);

    for (genvar i = 0; i < NVEC; i++) begin : g_dec
        assign set_vec[i] = accept && (msi_data[VIDX-1:0] == VIDX'(i));
    end
endmodule

// File: rtl/pirq_w1c_bank.sv
module pirq_w1c_bank #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set,
    input  logic [W-1:0] clr,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (!rst_n)
                q[i] <= 1'b0;
            else if (set[i])
                q[i] <= 1'b1;
            else if (clr[i])
                q[i] <= 1'b0;
        end

        AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            set[i] |=> q[i]);                                            // R5
    end
endmodule

// File: rtl/pirq_summary_fsm.sv
module pirq_summary_fsm
    import pirq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    input  logic clr_req,
    output logic pending
);
    sum_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= SUM_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SUM_IDLE: if (accept) state_d = SUM_PEND;
            SUM_PEND: if (clr_req && !accept) state_d = SUM_IDLE;
            default:  state_d = SUM_IDLE;
        endcase
    end

    always_comb begin
        pending = (state_q == SUM_PEND);
    end

    AST_SUM_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> pending);                                             // R4
    AST_SUM_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !clr_req) |=> pending);                              // R4
endmodule

// File: rtl/pcie_irq_collector.sv
module pcie_irq_collector
    import pirq_pkg::*;
#(
    parameter int NVEC = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [REG_AW-1:0]   reg_addr,
    input  logic [REG_DW-1:0]   reg_wdata,
    output logic [REG_DW-1:0]   reg_rdata,
    input  logic [N_INTX-1:0]   intx_assert,
    input  logic                msi_valid,
    input  logic [31:0]         msi_addr,
    input  logic [31:0]         msi_data,
    output logic                irq_out
);
    localparam int VIDX = (NVEC > 1) ? $clog2(NVEC) : 1;

    logic              wr_mask, wr_stat, wr_vec, wr_cap;
    logic [N_INTX-1:0] mask_intx;
    logic              mask_sum;
    logic [31:0]       cap_addr;
    logic              accept, drop;
    logic [NVEC-1:0]   set_vec, vec_q, vec_clr;
    logic [N_INTX-1:0] intx_q, intx_clr;
    logic              sum_q, err_q;
    logic              irq_q;
    logic [REG_DW-1:0] stat_word, mask_word;

    assign wr_mask = reg_wr && (reg_addr == OFS_MASK);
    assign wr_stat = reg_wr && (reg_addr == OFS_STAT);
    assign wr_vec  = reg_wr && (reg_addr == OFS_VEC);
    assign wr_cap  = reg_wr && (reg_addr == OFS_CAP);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_intx <= '1;
            mask_sum  <= 1'b1;
            cap_addr  <= '0;
        end else begin
            if (wr_mask) begin
                mask_intx <= reg_wdata[INTX_LSB +: N_INTX];
                mask_sum  <= reg_wdata[SUM_BIT];
            end
            if (wr_cap)
                cap_addr <= reg_wdata;
        end
    end

    pirq_msi_capture #(.NVEC(NVEC), .AW(32), .DW(32)) u_cap (
        .msi_valid (msi_valid),
        .msi_addr  (msi_addr),
        .msi_data  (msi_data),
        .cap_addr  (cap_addr),
        .accept    (accept),
        .drop      (drop),
        .set_vec   (set_vec)
    );

    assign vec_clr  = wr_vec  ? reg_wdata[NVEC-1:0] : '0;
    assign intx_clr = wr_stat ? reg_wdata[INTX_LSB +: N_INTX] : '0;

    pirq_w1c_bank #(.W(NVEC)) u_vec (
        .clk (clk), .rst_n (rst_n), .set (set_vec), .clr (vec_clr), .q (vec_q)
    );

    pirq_w1c_bank #(.W(N_INTX)) u_intx (
        .clk (clk), .rst_n (rst_n), .set (intx_assert), .clr (intx_clr), .q (intx_q)
    );

    pirq_w1c_bank #(.W(1)) u_err (
        .clk (clk), .rst_n (rst_n), .set (drop),
        .clr (wr_stat && reg_wdata[ERR_BIT]), .q (err_q)
    );

    pirq_summary_fsm u_sum (
        .clk     (clk),
        .rst_n   (rst_n),
        .accept  (accept),
        .clr_req (wr_stat && reg_wdata[SUM_BIT]),
        .pending (sum_q)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_q <= 1'b0;
        else
            irq_q <= (|(intx_q & ~mask_intx)) || (sum_q && !mask_sum);
    end
    assign irq_out = irq_q;

    always_comb begin
        stat_word = '0;
        stat_word[INTX_LSB +: N_INTX] = intx_q;
        stat_word[SUM_BIT] = sum_q;
        stat_word[ERR_BIT] = err_q;
        mask_word = '0;
        mask_word[INTX_LSB +: N_INTX] = mask_intx;
        mask_word[SUM_BIT] = mask_sum;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_MASK: reg_rdata = mask_word;
            OFS_STAT: reg_rdata = stat_word;
            OFS_VEC:  reg_rdata[NVEC-1:0] = vec_q;
            OFS_CAP:  reg_rdata = cap_addr;
            default:  reg_rdata = '0;
        endcase
    end

    AST_VEC_SET: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> vec_q[$past(msi_data[VIDX-1:0])]);                    // R3
    AST_DROP_NO_VEC: assert property (@(posedge clk) disable iff (!rst_n)
        (drop && !wr_vec) |=> (vec_q == $past(vec_q)));                  // R6
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        drop |=> err_q);                                                 // R6
    AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(&mask_intx) && $past(mask_sum)) |-> !irq_out);            // R7
endmodule

// File: tb/pcie_irq_collector_test.sv
`timescale 1ns/1ps
module pcie_irq_collector_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr;
    logic [11:0] reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic [3:0]  intx_assert;
    logic        msi_valid;
    logic [31:0] msi_addr;
    logic [31:0] msi_data;
    logic        irq_out;

    int n_chk = 0;
    int n_fail = 0;

    localparam logic [11:0] A_MASK = 12'h420;
    localparam logic [11:0] A_STAT = 12'h424;
    localparam logic [11:0] A_VEC  = 12'h42C;
    localparam logic [11:0] A_CAP  = 12'h430;
    localparam logic [31:0] CAP    = 32'h1000_0040;

    always #2.5 clk = ~clk;

    pcie_irq_collector uut (
        .clk (clk), .rst_n (rst_n), .reg_wr (reg_wr), .reg_addr (reg_addr),
        .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
        .intx_assert (intx_assert), .msi_valid (msi_valid),
        .msi_addr (msi_addr), .msi_data (msi_data), .irq_out (irq_out)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic msi(input logic [31:0] a, input logic [31:0] d);
        msi_valid = 1'b1; msi_addr = a; msi_data = d;
        @(posedge clk); @(negedge clk);
        msi_valid = 1'b0;
    endtask

    task automatic tick();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(A_MASK, v); check("R1 mask reset", v, 32'h008F_0000);
        rd(A_STAT, v); check("R1 status reset", v, 32'h0);
        rd(A_VEC, v);  check("R1 vector reset", v, 32'h0);
        rd(A_CAP, v);  check("R1 capture reset", v, 32'h0);
        check("R1 irq reset", 32'(irq_out), 32'h0);
    endtask

    task automatic t_mask_bits();
        logic [31:0] v;
        wr(A_MASK, 32'hFFFF_FFFF);
        rd(A_MASK, v); check("R9 mask writable bits", v, 32'h008F_0000);
        rd(12'h100, v); check("R10 unmapped read", v, 32'h0);
    endtask

    task automatic t_masked_record();
        logic [31:0] v;
        intx_assert = 4'b0010; tick(); intx_assert = 4'b0;
        rd(A_STAT, v); check("R2 intx status set", v, 32'h0002_0000);
        tick(); check("R8 masked irq low", 32'(irq_out), 32'h0);
        wr(A_MASK, 32'h0); tick();
        check("R8 unmask raises irq", 32'(irq_out), 32'h1);
        wr(A_STAT, 32'h0002_0000);
        rd(A_STAT, v); check("R2 intx w1c", v, 32'h0);
        tick(); check("R7 irq falls", 32'(irq_out), 32'h0);
    endtask

    task automatic t_msi();
        logic [31:0] v;
        wr(A_CAP, CAP);
        msi(CAP, 32'd5);
        rd(A_VEC, v); check("R3 vector 5", v, 32'h0000_0020);
        rd(A_STAT, v); check("R4 summary set", v, 32'h0080_0000);
        tick(); check("R7 irq from summary", 32'(irq_out), 32'h1);
        msi(CAP, 32'd31);
        rd(A_VEC, v); check("R3 vector 31", v, 32'h8000_0020);
        wr(A_VEC, 32'hFFFF_FFFF);
        rd(A_VEC, v); check("R3 vector w1c", v, 32'h0);
        rd(A_STAT, v); check("R4 summary survives drain", v, 32'h0080_0000);
        tick(); check("R4 irq held after drain", 32'(irq_out), 32'h1);
        wr(A_STAT, 32'h0080_0000);
        rd(A_STAT, v); check("R4 summary cleared", v, 32'h0);
        tick(); check("R7 irq low after clear", 32'(irq_out), 32'h0);
    endtask

    task automatic t_drop();
        logic [31:0] v;
        msi(CAP ^ 32'h4, 32'd3);
        rd(A_VEC, v); check("R6 bad address no vector", v, 32'h0);
        rd(A_STAT, v); check("R6 error bit only", v, 32'h0100_0000);
        tick(); check("R9 error not on irq", 32'(irq_out), 32'h0);
        msi(CAP, 32'd32);
        rd(A_VEC, v); check("R6 data 32 no vector", v, 32'h0);
        wr(A_STAT, 32'h0100_0000);
        rd(A_STAT, v); check("R6 error w1c", v, 32'h0);
    endtask

    task automatic t_collide();
        logic [31:0] v;
        msi(CAP, 32'd1);
        reg_wr = 1'b1; reg_addr = A_STAT; reg_wdata = 32'h0080_0000;
        msi_valid = 1'b1; msi_addr = CAP; msi_data = 32'd7;
        tick();
        reg_wr = 1'b0; msi_valid = 1'b0;
        rd(A_STAT, v); check("R5 summary set beats clear", v, 32'h0080_0000);
        reg_wr = 1'b1; reg_addr = A_VEC; reg_wdata = 32'h0000_0080;
        msi_valid = 1'b1; msi_data = 32'd7;
        tick();
        reg_wr = 1'b0; msi_valid = 1'b0;
        rd(A_VEC, v); check("R5 vector set beats clear", v, 32'h0000_0082);
        reg_wr = 1'b1; reg_addr = A_STAT; reg_wdata = 32'h0008_0000;
        intx_assert = 4'b1000;
        tick();
        reg_wr = 1'b0; intx_assert = 4'b0;
        rd(A_STAT, v); check("R5 intx set beats clear", v, 32'h0088_0000);
    endtask

    initial begin
        #(5.0 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
        intx_assert = '0; msi_valid = 1'b0; msi_addr = '0; msi_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mask_bits();
        t_masked_record();
        t_msi();
        t_drop();
        t_collide();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule